// File: doc/BRIEF.md
# Bank Row Activation Sequencer

This block sits between a memory-request front end and the command pins of a four-bank synchronous DRAM. The front end presents one request at a time: a bank, a row and a read/write flag. The block decides each clock which DRAM command may legally go out, and it raises a stall while the request has to wait. Each bank has its own tracker. The tracker holds whether a row is open, the number of that row, and down-counters for three delays: activate-to-access, activate-to-activate and precharge-to-activate.

The three delays are given as picosecond parameters together with the clock period. They are turned into whole cycles by rounding up. A request to a closed bank first gets an ACTIVE command. A request to a bank whose open row differs from the wanted row first gets a PRECHARGE and then an ACTIVE. A request that hits the open row goes out as READ or WRITE as soon as the activate-to-access delay has elapsed. The front end holds its request stable until the cycle in which stall is low; that cycle consumes the request.

The command pins are registered, so a command decided in one cycle appears on the pins in the next cycle. Exactly one command is driven per clock.

Top module: `row_act_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, the pins carry NOP, ba and addr are zero, and every bank is treated as closed.
- R2: The pin pattern {cs_n,ras_n,cas_n,we_n} is 0111 for NOP, 0011 for ACTIVE, 0010 for PRECHARGE, 0101 for READ and 0100 for WRITE. cke is always 1.
- R3: A READ or WRITE is never issued to a bank with no open row. A request to a closed bank first produces ACTIVE, with ba equal to the bank and addr equal to the requested row.
- R4: READ or WRITE to a bank appears on the pins no earlier than ceil(TRCD_PS/TCK_PS) cycles after that bank's ACTIVE. When the request is already waiting, the gap is exactly that many cycles.
- R5: A request that misses the open row of its bank produces PRECHARGE (ba = bank, addr = 0) before the bank is re-activated with the new row.
- R6: Two ACTIVE commands to the same bank are at least ceil(TRC_PS/TCK_PS) cycles apart.
- R7: An ACTIVE follows a PRECHARGE of the same bank by at least ceil(TRP_PS/TCK_PS) cycles.
- R8: stall is high exactly when req_valid is high and no READ or WRITE for the request is being decided in this cycle.
- R9: Exactly one command is driven per cycle. With no request, or while a delay is pending, the pins carry NOP with ba and addr zero. READ and WRITE drive addr zero and ba equal to the bank.
- R10: A request that hits the open row after the activate-to-access delay has expired is accepted in the same cycle (stall low) and appears as READ or WRITE on the next cycle.
- R11: Banks are independent. Opening or holding a row in one bank does not delay or change a hit in another bank.
- R12: Each delay is rounded up to whole cycles, with a minimum of one cycle. With the defaults (8000 ps clock, 20000/66000/20000 ps) the delays are 3, 9 and 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Front-end request present |
| req_bank | input | 2 | Requested bank |
| req_row | input | 13 | Requested row |
| req_write | input | 1 | 1 = write, 0 = read |
| stall | output | 1 | Request cannot be accepted this cycle |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 13 | Row address on ACTIVE, zero otherwise |

## Verification
The bench measures three gaps and expects each to equal its rounded cycle count: the gap from ACTIVE to an access request that is already waiting, the gap from a row miss to the next ACTIVE while activate-to-activate limits the bank, and the gap while precharge recovery limits it. A rounding error shows up here as a gap one cycle short or one cycle long. An immediate hit after the first access must be accepted with zero stall cycles; a design that re-activates the row, or waits again, gets that case wrong. A hit in one bank while another bank holds a row checks that the counters are per bank. Random traffic over a few rows per bank drives misses, hits and idle gaps against a bench model. Any stall or command that comes a cycle early or late is reported.

// File: rtl/row_act_pkg.sv
package row_act_pkg;

    // Pin pattern {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_PRE = 4'b0010,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100
    } dram_cmd_e;

    // Per-bank view handed to the command selector
    typedef struct packed {
        logic is_open;
        logic rcd_ok;
        logic rc_ok;
        logic rp_ok;
    } bank_view_t;

    // Round a picosecond limit up to whole clocks, never below one
    function automatic int cyc_ceil(input int lim_ps, input int tck_ps);
        int r;
        r = (lim_ps + tck_ps - 1) / tck_ps;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bank_timer.sv
module bank_timer
    import row_act_pkg::*;
#(
    parameter int ROW_W   = 13,
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 9,
    parameter int RP_CYC  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] act_row,
    output bank_view_t       view,
    output logic [ROW_W-1:0] open_row
);
    localparam int MAXC = max3(RCD_CYC, RC_CYC, RP_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    logic          open_q;
    logic [CW-1:0] rcd_cnt, rc_cnt, rp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q   <= 1'b0;
            open_row <= '0;
            rcd_cnt  <= '0;
            rc_cnt   <= '0;
            rp_cnt   <= '0;
        end else begin
            if (act_fire) begin
                open_q   <= 1'b1;
                open_row <= act_row;
                rcd_cnt  <= CW'(RCD_CYC - 1);
                rc_cnt   <= CW'(RC_CYC - 1);
            end else begin
                if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - 1'b1;
                if (rc_cnt  != '0) rc_cnt  <= rc_cnt - 1'b1;
            end
            if (pre_fire) begin
                open_q <= 1'b0;
                rp_cnt <= CW'(RP_CYC - 1);
            end else if (rp_cnt != '0) begin
                rp_cnt <= rp_cnt - 1'b1;
            end
        end
    end

    assign view.is_open = open_q;
    assign view.rcd_ok  = (rcd_cnt == '0);
    assign view.rc_ok   = (rc_cnt == '0);
    assign view.rp_ok   = (rp_cnt == '0);

    // Re-activation only after the bank has been closed
    assert_act_on_closed_R5: assert property (@(posedge clk) disable iff (rst)
        act_fire |-> !open_q);
    // Precharge only targets an open bank
    assert_pre_on_open_R5: assert property (@(posedge clk) disable iff (rst)
        pre_fire |-> open_q);
    // One command per bank per cycle
    assert_single_fire_R9: assert property (@(posedge clk) disable iff (rst)
        !(act_fire && pre_fire));

endmodule

// File: rtl/cmd_select.sv
module cmd_select
    import row_act_pkg::*;
#(
    parameter int NB    = 4,
    parameter int ROW_W = 13,
    parameter int BA_W  = 2
) (
    input  logic                      req_valid,
    input  logic [BA_W-1:0]           req_bank,
    input  logic [ROW_W-1:0]          req_row,
    input  logic                      req_write,
    input  bank_view_t [NB-1:0]       views,
    input  logic [NB-1:0][ROW_W-1:0]  rows,
    output dram_cmd_e                 cmd,
    output logic                      stall
);
    bank_view_t       v;
    logic [ROW_W-1:0] r;

    always_comb begin
        v   = views[req_bank];
        r   = rows[req_bank];
        cmd = CMD_NOP;
        if (req_valid) begin
            if (v.is_open && (r == req_row)) begin
                if (v.rcd_ok) cmd = req_write ? CMD_WR : CMD_RD;
            end else if (v.is_open) begin
                cmd = CMD_PRE;
            end else if (v.rc_ok && v.rp_ok) begin
                cmd = CMD_ACT;
            end
        end
        stall = req_valid && !((cmd == CMD_RD) || (cmd == CMD_WR));
    end

endmodule

// File: rtl/row_act_tracker.sv
module row_act_tracker
    import row_act_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int TCK_PS    = 8000,
    parameter int TRCD_PS   = 20000,
    parameter int TRC_PS    = 66000,
    parameter int TRP_PS    = 20000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]             req_row,
    input  logic                         req_write,
    output logic                         stall,
    output logic                         cke,
    output logic                         cs_n,
    output logic                         ras_n,
    output logic                         cas_n,
    output logic                         we_n,
    output logic [$clog2(NUM_BANKS)-1:0] ba,
    output logic [ROW_W-1:0]             addr
);
    localparam int BA_W    = $clog2(NUM_BANKS);
    localparam int RCD_CYC = cyc_ceil(TRCD_PS, TCK_PS);
    localparam int RC_CYC  = cyc_ceil(TRC_PS, TCK_PS);
    localparam int RP_CYC  = cyc_ceil(TRP_PS, TCK_PS);
    localparam int SW      = $clog2(RCD_CYC + RC_CYC + RP_CYC + 2) + 1;

    bank_view_t [NUM_BANKS-1:0]            views;
    logic       [NUM_BANKS-1:0][ROW_W-1:0] rows;
    logic       [NUM_BANKS-1:0]            act_fire, pre_fire;
    dram_cmd_e                             sel_cmd, cmd_q;

    cmd_select #(.NB(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)) u_sel (
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_write (req_write),
        .views     (views),
        .rows      (rows),
        .cmd       (sel_cmd),
        .stall     (stall)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_fire[b] = (sel_cmd == CMD_ACT) && (req_bank == BA_W'(b));
        assign pre_fire[b] = (sel_cmd == CMD_PRE) && (req_bank == BA_W'(b));

        bank_timer #(
            .ROW_W(ROW_W), .RCD_CYC(RCD_CYC), .RC_CYC(RC_CYC), .RP_CYC(RP_CYC)
        ) u_bank (
            .clk      (clk),
            .rst      (rst),
            .act_fire (act_fire[b]),
            .pre_fire (pre_fire[b]),
            .act_row  (req_row),
            .view     (views[b]),
            .open_row (rows[b])
        );
    end

    // Registered command pins
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
        end else begin
            cmd_q <= sel_cmd;
            ba    <= (sel_cmd == CMD_NOP) ? '0 : req_bank;
            addr  <= (sel_cmd == CMD_ACT) ? req_row : '0;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign cke = 1'b1;

    // Pin-level spacing monitors, one set per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mon
        logic [SW-1:0] since_act, since_pre;
        logic          pin_open;
        logic          pin_act, pin_pre, pin_acc;

        assign pin_act = (cmd_q == CMD_ACT) && (ba == BA_W'(b));
        assign pin_pre = (cmd_q == CMD_PRE) && (ba == BA_W'(b));
        assign pin_acc = ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) && (ba == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                since_act <= '1;
                since_pre <= '1;
                pin_open  <= 1'b0;
            end else begin
                if (pin_act)             since_act <= SW'(1);
                else if (since_act != '1) since_act <= since_act + 1'b1;
                if (pin_pre)             since_pre <= SW'(1);
                else if (since_pre != '1) since_pre <= since_pre + 1'b1;
                if (pin_act)      pin_open <= 1'b1;
                else if (pin_pre) pin_open <= 1'b0;
            end
        end

        assert_access_needs_open_R3: assert property (@(posedge clk) disable iff (rst)
            pin_acc |-> pin_open);
        assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (rst)
            pin_acc |-> (since_act >= SW'(RCD_CYC)));
        assert_rc_gap_R6: assert property (@(posedge clk) disable iff (rst)
            pin_act |-> (since_act >= SW'(RC_CYC)));
        assert_rp_gap_R7: assert property (@(posedge clk) disable iff (rst)
            pin_act |-> (since_pre >= SW'(RP_CYC)));
    end

    assert_stall_vs_pins_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !stall) |=> ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)));

endmodule

// File: tb/row_act_tracker_tb_top.sv
module row_act_tracker_tb_top;

    localparam int NB  = 4;
    localparam int RW  = 13;
    localparam int SAT = 1000;

    function automatic int up_div(input int a, input int b);
        int r;
        r = (a + b - 1) / b;
        return (r < 1) ? 1 : r;
    endfunction

    localparam int TRCD_EXP = up_div(20000, 8000);
    localparam int TRC_EXP  = up_div(66000, 8000);
    localparam int TRP_EXP  = up_div(20000, 8000);

    localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_PRE = 4'b0010,
                           P_RD  = 4'b0101, P_WR  = 4'b0100;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write;
    logic [1:0]    req_bank;
    logic [RW-1:0] req_row;
    logic          stall, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]    ba;
    logic [RW-1:0] addr;

    always #5 clk = ~clk;

    row_act_tracker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .req_write(req_write), .stall(stall), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    int checks = 0;
    int errors = 0;

    // Bench model
    logic          m_open [NB];
    logic [RW-1:0] m_row  [NB];
    int            age_act [NB];
    int            age_pre [NB];
    logic [3:0]    exp_cmd;
    logic [1:0]    exp_ba;
    logic [RW-1:0] exp_addr;
    int            gap_rd, gap_act_act, gap_pre_act;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Advance one clock, compare pins with the decision made before the edge
    task automatic step();
        logic [3:0] got;
        string tag;
        @(negedge clk);
        got = {cs_n, ras_n, cas_n, we_n};
        case (exp_cmd)
            P_ACT:   tag = "R3 R2";
            P_PRE:   tag = "R5 R2";
            P_RD:    tag = "R4 R2 R9";
            P_WR:    tag = "R4 R2 R9";
            default: tag = "R9 R2";
        endcase
        chk(got == exp_cmd, tag, "command", 32'(got), 32'(exp_cmd));
        chk(ba == exp_ba && addr == exp_addr && cke == 1'b1, tag, "ba/addr/cke",
            {15'd0, cke, ba, addr}, {15'd0, 1'b1, exp_ba, exp_addr});
        for (int b = 0; b < NB; b++) begin
            if (age_act[b] < SAT) age_act[b]++;
            if (age_pre[b] < SAT) age_pre[b]++;
        end
        if (exp_cmd == P_ACT) begin
            gap_act_act = age_act[exp_ba];
            gap_pre_act = age_pre[exp_ba];
            age_act[exp_ba] = 0;
            m_open[exp_ba]  = 1'b1;
            m_row[exp_ba]   = exp_addr;
        end else if (exp_cmd == P_PRE) begin
            age_pre[exp_ba] = 0;
            m_open[exp_ba]  = 1'b0;
        end else if (exp_cmd == P_RD || exp_cmd == P_WR) begin
            gap_rd = age_act[exp_ba];
        end
    endtask

    // Settle current inputs, check stall, record the expected next command
    task automatic decide();
        bit  rw;
        int  b;
        #1;
        b        = int'(req_bank);
        exp_cmd  = P_NOP;
        exp_ba   = '0;
        exp_addr = '0;
        if (req_valid) begin
            if (m_open[b] && m_row[b] == req_row) begin
                if (age_act[b] + 1 >= TRCD_EXP) begin
                    exp_cmd = req_write ? P_WR : P_RD;
                    exp_ba  = req_bank;
                end
            end else if (m_open[b]) begin
                exp_cmd = P_PRE;
                exp_ba  = req_bank;
            end else if (age_act[b] + 1 >= TRC_EXP && age_pre[b] + 1 >= TRP_EXP) begin
                exp_cmd  = P_ACT;
                exp_ba   = req_bank;
                exp_addr = req_row;
            end
        end
        rw = (exp_cmd == P_RD) || (exp_cmd == P_WR);
        chk(stall == (req_valid && !rw), "R8", "stall", 32'(stall), 32'(req_valid && !rw));
    endtask

    task automatic run_req(input logic [1:0] b, input logic [RW-1:0] r,
                           input logic w, output int waits);
        req_valid = 1'b1;
        req_bank  = b;
        req_row   = r;
        req_write = w;
        waits     = 0;
        forever begin
            decide();
            if (exp_cmd == P_RD || exp_cmd == P_WR) break;
            waits++;
            if (waits > 2000) begin
                chk(1'b0, "R8", "request never accepted", 32'(waits), 32'd0);
                break;
            end
            step();
        end
        step();
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            decide();
            step();
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int w;
        logic [RW-1:0] row_pool [4];
        row_pool[0] = 13'd0;
        row_pool[1] = 13'd3;
        row_pool[2] = 13'd9;
        row_pool[3] = 13'h1FFF;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) begin
            m_open[b] = 1'b0;
            m_row[b]  = '0;
            age_act[b] = SAT;
            age_pre[b] = SAT;
        end
        exp_cmd = P_NOP; exp_ba = '0; exp_addr = '0;
        rst = 1'b1; req_valid = 1'b0; req_bank = '0; req_row = '0; req_write = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({cs_n, ras_n, cas_n, we_n} == P_NOP && ba == 0 && addr == 0 && cke,
            "R1", "reset pins", {cs_n, ras_n, cas_n, we_n}, P_NOP);
        chk(stall == 1'b0, "R1", "reset stall idle", 32'(stall), 32'd0);
        rst = 1'b0;
        idle(2);

        // R12: rounding of the three limits
        chk(TRCD_EXP == 3 && TRC_EXP == 9 && TRP_EXP == 3, "R12", "rounded cycles",
            32'(TRCD_EXP * 100 + TRC_EXP * 10 + TRP_EXP), 32'd393);

        // R3 R4: read to a closed bank, waiting request gets exact tRCD gap
        run_req(2'd0, 13'd5, 1'b0, w);
        chk(gap_rd == TRCD_EXP, "R4", "ACT to READ gap", 32'(gap_rd), 32'(TRCD_EXP));
        chk(w == TRCD_EXP, "R3", "stall cycles on closed bank", 32'(w), 32'(TRCD_EXP));

        // R10: immediate hit accepted without stall
        run_req(2'd0, 13'd5, 1'b1, w);
        chk(w == 0, "R10", "hit wait cycles", 32'(w), 32'd0);

        // R5 R6: row miss while tRC still running
        run_req(2'd0, 13'd7, 1'b0, w);
        chk(gap_act_act == TRC_EXP, "R6", "ACT to ACT gap", 32'(gap_act_act), 32'(TRC_EXP));

        // R11: another bank opens, bank 0 hit unaffected
        run_req(2'd1, 13'd4, 1'b1, w);
        run_req(2'd0, 13'd7, 1'b0, w);
        chk(w == 0, "R11", "hit in bank 0 with bank 1 open", 32'(w), 32'd0);

        // R7: miss long after ACT, precharge recovery is the limit
        run_req(2'd2, 13'd1, 1'b0, w);
        idle(12);
        run_req(2'd2, 13'd2, 1'b0, w);
        chk(gap_pre_act == TRP_EXP, "R7", "PRE to ACT gap", 32'(gap_pre_act), 32'(TRP_EXP));

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            run_req(2'($urandom % NB), row_pool[$urandom % 4], 1'($urandom % 2), w);
            idle(int'($urandom % 3));
        end
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule